// File: doc/BRIEF.md
# DMA Transfer Size Splitter

This block takes one DMA transfer and turns it into a series of system-bus transaction requests. The transfer is described by a local-bus start address, a peripheral-bus start address, a byte count and a programmed transaction size. The size is one 32-bit word, one 64-bit word, or a burst of four 64-bit words, and it holds for every transaction in the transfer. A `start` pulse loads the settings. The block first checks that they are legal. If they are, it issues requests on a valid/ready interface. The addresses go up and the count goes down after each accepted request, until nothing is left.

The wide sizes need both addresses to sit on a 64-bit boundary and the count to be a multiple of 8. Any setting that breaks this rule, and the reserved size code, gives a one-cycle `config_error` and no requests. The request interface follows the usual back-pressure rules. While `req_valid` is high and `req_ready` is low, the request fields hold steady. A request is consumed only on a cycle where both are high. The consumer may hold `req_ready` low for as long as it needs.

Top module: `dma_xfer_splitter`

## Requirements
- R1: `cfg_size` 2'b00 (4-byte word) is always legal. 2'b01 (8-byte word) and 2'b10 (four 8-byte words as a burst) are legal only when bits [2:0] of `cfg_lcl_addr`, bits [2:0] of `cfg_per_addr` and bits [2:0] of `cfg_count` are all zero. 2'b11 is reserved and is always illegal.
- R2: A `start` with an illegal setting raises `config_error` for exactly the cycle after the start edge. It issues no request and no `done`.
- R3: A legal `start` with `cfg_count` zero raises `done` for the cycle after the start edge and issues no request.
- R4: In 4-byte mode each request has `req_bytes`=4 and `req_burst`=0. If the remaining count is below 4, the last request carries the remaining count.
- R5: In 8-byte mode every request has `req_bytes`=8 and `req_burst`=0.
- R6: In burst mode a request has `req_bytes`=32 and `req_burst`=1 while at least 32 bytes remain. A shorter tail is finished with 8-byte requests that have `req_burst`=0.
- R7: The first request shows the programmed addresses. After each accepted request (`req_valid` and `req_ready` both high at an edge), both addresses advance by that request's `req_bytes`, and the remaining count drops by the same amount.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, both addresses and `req_bytes` hold steady.
- R9: `done` is high for the single cycle after the edge that accepts the final request. `req_valid` is low in that cycle.
- R10: `start` is ignored while a transfer is in progress.
- R11: After reset `req_valid`, `done`, `config_error` and `busy` are low. A non-empty legal start raises `req_valid` and `busy` in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load settings and begin a transfer (ignored when busy) |
| cfg_lcl_addr | input | AW | Local-bus start address |
| cfg_per_addr | input | AW | Peripheral-bus start address |
| cfg_count | input | CW | Byte count |
| cfg_size | input | 2 | Transaction size code |
| busy | output | 1 | Transfer in progress |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Consumer accepts request |
| req_lcl_addr | output | AW | Local-bus address of request |
| req_per_addr | output | AW | Peripheral-bus address of request |
| req_bytes | output | 6 | Bytes moved by request |
| req_burst | output | 1 | Request is a four-word burst |
| done | output | 1 | Transfer finished pulse |
| config_error | output | 1 | Illegal setting pulse |

## Verification
`config_error`, the zero-count `done`, and the first `req_valid` all appear one cycle after the start edge. The bench samples each of them at the falling edge that follows that start edge. Every later request is due in the cycle after the previous handshake edge, and the final `done` comes in the cycle after the last handshake. The bench changes its reference state only after a rising edge where it drove `req_ready` high, and it compares at the next falling edge. This means stalled cycles are checked against unchanged expected values.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    SZ_WORD  = 2'b00,
    SZ_DWORD = 2'b01,
    SZ_BURST = 2'b10,
    SZ_RSVD  = 2'b11
  } xfer_size_e;

  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned DWORD_BYTES = 8;
  localparam int unsigned BURST_BYTES = 32;
  localparam int unsigned BYTES_W     = 6;
endpackage

// File: rtl/dma_split_legal.sv
module dma_split_legal
  import dma_split_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic [AW-1:0] lcl_addr,
  input  logic [AW-1:0] per_addr,
  input  logic [CW-1:0] count,
  input  xfer_size_e    size,
  output logic          legal
);
  logic aligned;

  always_comb begin
    aligned = (lcl_addr[2:0] == 3'd0) && (per_addr[2:0] == 3'd0) && (count[2:0] == 3'd0);
    unique case (size)
      SZ_WORD:           legal = 1'b1;
      SZ_DWORD, SZ_BURST: legal = aligned;
      default:           legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_split_step.sv
module dma_split_step
  import dma_split_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  xfer_size_e         size,
  input  logic [CW-1:0]      remaining,
  output logic [BYTES_W-1:0] bytes,
  output logic               burst
);
  always_comb begin
    bytes = BYTES_W'(WORD_BYTES);
    burst = 1'b0;
    unique case (size)
      SZ_WORD: begin
        if (remaining < CW'(WORD_BYTES)) bytes = BYTES_W'(remaining);
      end
      SZ_DWORD: bytes = BYTES_W'(DWORD_BYTES);
      SZ_BURST: begin
        if (remaining >= CW'(BURST_BYTES)) begin
          bytes = BYTES_W'(BURST_BYTES);
          burst = 1'b1;
        end else begin
          bytes = BYTES_W'(DWORD_BYTES);
        end
      end
      default: bytes = BYTES_W'(WORD_BYTES);
    endcase
  end
endmodule

// File: rtl/dma_split_seq.sv
module dma_split_seq
  import dma_split_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               legal,
  input  logic [AW-1:0]      cfg_lcl_addr,
  input  logic [AW-1:0]      cfg_per_addr,
  input  logic [CW-1:0]      cfg_count,
  input  xfer_size_e         cfg_size,
  input  logic [BYTES_W-1:0] step_bytes,
  input  logic               req_ready,
  output xfer_size_e         cur_size,
  output logic [CW-1:0]      remaining,
  output logic               busy,
  output logic [AW-1:0]      lcl_addr,
  output logic [AW-1:0]      per_addr,
  output logic               done,
  output logic               config_error
);
  logic accept;
  logic last;

  assign accept = busy && req_ready;
  assign last   = (remaining == CW'(step_bytes));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      config_error <= 1'b0;
      lcl_addr     <= '0;
      per_addr     <= '0;
      remaining    <= '0;
      cur_size     <= SZ_WORD;
    end else begin
      done         <= 1'b0;
      config_error <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (!legal) begin
            config_error <= 1'b1;
          end else if (cfg_count == '0) begin
            done <= 1'b1;
          end else begin
            busy      <= 1'b1;
            lcl_addr  <= cfg_lcl_addr;
            per_addr  <= cfg_per_addr;
            remaining <= cfg_count;
            cur_size  <= cfg_size;
          end
        end
      end else if (accept) begin
        lcl_addr  <= lcl_addr + AW'(step_bytes);
        per_addr  <= per_addr + AW'(step_bytes);
        remaining <= remaining - CW'(step_bytes);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_ready |=> busy && $stable(lcl_addr) && $stable(per_addr) && $stable(remaining)); // R8
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last |=> lcl_addr == $past(lcl_addr) + AW'($past(step_bytes))); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !busy && !done); // R2
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_ready |=> !config_error); // R10
endmodule

// File: rtl/dma_xfer_splitter.sv
module dma_xfer_splitter
  import dma_split_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [AW-1:0]      cfg_lcl_addr,
  input  logic [AW-1:0]      cfg_per_addr,
  input  logic [CW-1:0]      cfg_count,
  input  logic [1:0]         cfg_size,
  output logic               busy,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [AW-1:0]      req_lcl_addr,
  output logic [AW-1:0]      req_per_addr,
  output logic [BYTES_W-1:0] req_bytes,
  output logic               req_burst,
  output logic               done,
  output logic               config_error
);
  logic       legal;
  xfer_size_e cur_size;
  logic [CW-1:0] remaining;

  dma_split_legal #(.AW(AW), .CW(CW)) u_legal (
    .lcl_addr (cfg_lcl_addr),
    .per_addr (cfg_per_addr),
    .count    (cfg_count),
    .size     (xfer_size_e'(cfg_size)),
    .legal    (legal)
  );

  dma_split_step #(.CW(CW)) u_step (
    .size      (cur_size),
    .remaining (remaining),
    .bytes     (req_bytes),
    .burst     (req_burst)
  );

  dma_split_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .legal        (legal),
    .cfg_lcl_addr (cfg_lcl_addr),
    .cfg_per_addr (cfg_per_addr),
    .cfg_count    (cfg_count),
    .cfg_size     (xfer_size_e'(cfg_size)),
    .step_bytes   (req_bytes),
    .req_ready    (req_ready),
    .cur_size     (cur_size),
    .remaining    (remaining),
    .busy         (busy),
    .lcl_addr     (req_lcl_addr),
    .per_addr     (req_per_addr),
    .done         (done),
    .config_error (config_error)
  );

  assign req_valid = busy;

  AST_BURST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_burst |-> req_bytes == BYTES_W'(BURST_BYTES)); // R6
  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_bytes != '0 && req_bytes <= BYTES_W'(BURST_BYTES)); // R4
endmodule

// File: tb/dma_xfer_splitter_tb.sv
module dma_xfer_splitter_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cfg_lcl_addr = '0;
  logic [AW-1:0] cfg_per_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0] cfg_size = '0;
  logic req_ready = 1'b0;
  logic busy, req_valid, req_burst, done, config_error;
  logic [AW-1:0] req_lcl_addr, req_per_addr;
  logic [5:0] req_bytes;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dma_xfer_splitter #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_lcl_addr(cfg_lcl_addr), .cfg_per_addr(cfg_per_addr),
    .cfg_count(cfg_count), .cfg_size(cfg_size),
    .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_lcl_addr(req_lcl_addr), .req_per_addr(req_per_addr),
    .req_bytes(req_bytes), .req_burst(req_burst),
    .done(done), .config_error(config_error)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [AW-1:0] l, input logic [AW-1:0] p,
                                  input logic [CW-1:0] c, input logic [1:0] s);
    if (s == 2'b00) return 1'b1;
    if (s == 2'b11) return 1'b0;
    return (l[2:0] == 0) && (p[2:0] == 0) && (c[2:0] == 0);
  endfunction

  function automatic int exp_bytes(input logic [1:0] s, input int rem);
    if (s == 2'b00) return (rem < 4) ? rem : 4;
    if (s == 2'b01) return 8;
    return (rem >= 32) ? 32 : 8;
  endfunction

  task automatic run_xfer(input logic [AW-1:0] l, input logic [AW-1:0] p,
                          input logic [CW-1:0] c, input logic [1:0] s,
                          input int ready_pct, input bit poke_busy);
    bit lg;
    logic [AW-1:0] el, ep;
    int rem, b;
    bit rdy;
    bit poked;
    lg = is_legal(l, p, c, s);
    @(negedge clk);
    cfg_lcl_addr = l; cfg_per_addr = p; cfg_count = c; cfg_size = s;
    start = 1'b1; req_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (!lg) begin
      chk("R2 config_error", config_error, 1);
      chk("R2 no request", req_valid, 0);
      chk("R2 no done", done, 0);
      @(negedge clk);
      chk("R2 error one cycle", config_error, 0);
      chk("R2 still idle", req_valid, 0);
      return;
    end
    chk("R1 legal no error", config_error, 0);
    if (c == 0) begin
      chk("R3 zero count done", done, 1);
      chk("R3 no request", req_valid, 0);
      @(negedge clk);
      chk("R3 done one cycle", done, 0);
      return;
    end
    chk("R11 valid after start", req_valid, 1);
    chk("R11 busy after start", busy, 1);
    el = l; ep = p; rem = int'(c); poked = 1'b0;
    forever begin
      b = exp_bytes(s, rem);
      chk("R7 lcl addr", req_lcl_addr, el);
      chk("R7 per addr", req_per_addr, ep);
      chk(s == 2'b00 ? "R4 bytes" : (s == 2'b01 ? "R5 bytes" : "R6 bytes"), req_bytes, b);
      chk("R6 burst flag", req_burst, (b == 32) ? 1 : 0);
      chk("R8 valid held", req_valid, 1);
      rdy = ($urandom_range(99) < ready_pct);
      if (poke_busy && !poked) begin
        rdy = 1'b0; poked = 1'b1;
        cfg_lcl_addr = 32'h0000_1001; cfg_size = 2'b11; cfg_count = 0;
        start = 1'b1;
      end
      req_ready = rdy;
      @(posedge clk);
      @(negedge clk);
      if (start) begin
        start = 1'b0;
        chk("R10 start ignored no error", config_error, 0);
        chk("R10 start ignored no done", done, 0);
      end
      req_ready = 1'b0;
      if (rdy) begin
        el += AW'(b); ep += AW'(b); rem -= b;
        if (rem == 0) begin
          chk("R9 done after last", done, 1);
          chk("R9 valid low at done", req_valid, 0);
          @(negedge clk);
          chk("R9 done one cycle", done, 0);
          return;
        end
        chk("R9 no early done", done, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 reset valid", req_valid, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset error", config_error, 0);
    chk("R11 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_xfer(32'h100, 32'h200, 16'd16, 2'b00, 100, 1'b0);   // R4
    run_xfer(32'h101, 32'h203, 16'd10, 2'b00, 60, 1'b0);    // R4 tail of 2
    run_xfer(32'h100, 32'h200, 16'd40, 2'b01, 50, 1'b0);    // R5
    run_xfer(32'h100, 32'h200, 16'd72, 2'b10, 70, 1'b0);    // R6 two bursts plus one 8
    run_xfer(32'h104, 32'h200, 16'd64, 2'b01, 50, 1'b0);    // R1 misaligned lcl
    run_xfer(32'h100, 32'h20c, 16'd64, 2'b10, 50, 1'b0);    // R1 misaligned per
    run_xfer(32'h100, 32'h200, 16'd12, 2'b10, 50, 1'b0);    // R1 count not x8
    run_xfer(32'h100, 32'h200, 16'd32, 2'b11, 50, 1'b0);    // R1 reserved
    run_xfer(32'h100, 32'h200, 16'd0, 2'b01, 50, 1'b0);     // R3
    run_xfer(32'h100, 32'h200, 16'd0, 2'b11, 50, 1'b0);     // R2 reserved, zero count
    run_xfer(32'h100, 32'h200, 16'd48, 2'b10, 30, 1'b1);    // R10 and R8
    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic [AW-1:0] l, p;
      logic [CW-1:0] c;
      logic [1:0] s;
      l = $urandom; p = $urandom;
      c = CW'($urandom_range(200));
      s = 2'($urandom_range(3));
      if ($urandom_range(3) != 0) begin
        l[2:0] = 0; p[2:0] = 0; c[2:0] = 0;
      end
      run_xfer(l, p, c, s, 20 + $urandom_range(80), ($urandom_range(9) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule